// File: doc/BRIEF.md
# E1 Time Slot 16 Multiframe Alarm Monitor

This block watches time slot 16 of an E1 stream that carries channel associated signalling. Once per frame the framer presents the TS16 octet with a strobe and the number of that frame within the 16-frame signalling multiframe. The block keeps three status levels. The first is loss of multiframe alignment, declared either from missing alignment words or from a run of empty octets. The second is an alarm indication signal carried inside TS16. The third is the far end's multiframe alarm bit.

Each status has an event output that pulses for one cycle. These pulses are meant to feed an interrupt register. The event for multiframe loss has two modes: it can pulse only when loss is declared, or on every change of the loss status. The block does not search for alignment and does not extract signalling bits.

Top module: `e1_ts16_alarm_mon`

## Requirements
- R1: After synchronous reset, `mf_loss`, `ais16`, `rmt_alarm` and all three event outputs are 0.
- R2: A frame-0 octet "matches" when its upper four bits (bits 7..4) are 0000. Two consecutive frame-0 octets that do not match set `mf_loss`. A single mismatch followed by a match does not set it.
- R3: 16 consecutive strobed octets equal to 0x00, in any frames, set `mf_loss` on the 16th. A run of 15 does not set it.
- R4: A matching frame-0 octet clears `mf_loss`, unless that octet completes or extends a run of 16 or more all-zero octets. Clearing starts again only after a non-zero octet.
- R5: With `cos_mode`=0, `ev_mf_loss` pulses only when `mf_loss` goes 0 to 1. With `cos_mode`=1, it pulses on both rising and falling changes of `mf_loss`.
- R6: The zero bits of the 16 octets of frames 0..15 are counted, and the count restarts at frame 0. At the frame-15 octet, a multiframe with fewer than 4 zeros is "quiet". `ais16` is set when two consecutive multiframes are quiet.
- R7: `ais16` clears at the end of any multiframe holding 4 or more zero bits.
- R8: `ev_ais16` pulses for one cycle whenever `ais16` changes, in either direction.
- R9: `rmt_alarm` follows bit 2 of each matching frame-0 octet. Frame-0 octets that do not match, and octets of other frames, leave it unchanged. `ev_rmt_alarm` pulses whenever it changes.
- R10: All outputs change only on the clock edge that takes a strobed octet. Without a strobe, the levels hold and no event pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts16_valid | input | 1 | One-cycle strobe per frame, TS16 octet valid |
| ts16_octet | input | 8 | TS16 octet, bit 7 first on the line |
| frame_num | input | 4 | Frame number within the 16-frame multiframe |
| cos_mode | input | 1 | 1: loss event on every change; 0: loss event on declaration only |
| mf_loss | output | 1 | Multiframe alignment lost |
| ais16 | output | 1 | TS16 alarm indication signal present |
| rmt_alarm | output | 1 | Far-end multiframe alarm bit |
| ev_mf_loss | output | 1 | One-cycle event for multiframe loss |
| ev_ais16 | output | 1 | One-cycle event on TS16 AIS change |
| ev_rmt_alarm | output | 1 | One-cycle event on remote alarm change |

## Verification
Every level and event is registered once, behind the strobe. A result is therefore due on the same rising edge that takes the strobed octet, and the event output stays high only until the next edge. The bench drives each octet for one cycle starting on a falling edge. It reads the levels and events on the following falling edge, which lies between the edge that updates them and the edge that clears the event. AIS results are checked both after frame 14 and after frame 15, which confirms that the decision lands exactly on the closing octet of the multiframe.

// File: rtl/e1_ts16_pkg.sv
package e1_ts16_pkg;
  typedef struct packed {
    logic loss;
    logic ais;
    logic rmt;
  } ts16_flags_t;

  localparam int unsigned DEF_OCTET_W  = 8;
  localparam int unsigned DEF_MF_LEN   = 16;
  localparam int unsigned DEF_MISS_MAX = 2;
  localparam int unsigned DEF_ZRUN     = 16;
  localparam int unsigned DEF_AIS_MIN  = 4;
  localparam int unsigned DEF_RA_BIT   = 2;
endpackage

// File: rtl/ts16_mf_align_mon.sv
module ts16_mf_align_mon #(
  parameter int unsigned OCTET_W  = 8,
  parameter int unsigned MISS_MAX = 2,
  parameter int unsigned ZRUN     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic               is_f0,
  input  logic [OCTET_W-1:0] octet,
  input  logic               cos_mode,
  output logic               loss,
  output logic               loss_ev
);
  localparam int unsigned ZW = $clog2(ZRUN + 1);
  localparam int unsigned MW = $clog2(MISS_MAX + 1);

  logic [ZW-1:0] zrun_q, zrun_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          pat_ok, run_hit, loss_d;

  always_comb begin
    pat_ok = is_f0 && (octet[OCTET_W-1 -: 4] == 4'b0000);
    if (octet != '0)
      zrun_d = '0;
    else if (zrun_q == ZW'(ZRUN))
      zrun_d = zrun_q;
    else
      zrun_d = zrun_q + 1'b1;
    run_hit = (zrun_d == ZW'(ZRUN));

    miss_d = miss_q;
    if (is_f0) begin
      if (pat_ok)
        miss_d = '0;
      else if (miss_q != MW'(MISS_MAX))
        miss_d = miss_q + 1'b1;
    end

    loss_d = loss;
    if (run_hit || (miss_d == MW'(MISS_MAX)))
      loss_d = 1'b1;
    else if (pat_ok)
      loss_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun_q  <= '0;
      miss_q  <= '0;
      loss    <= 1'b0;
      loss_ev <= 1'b0;
    end else if (stb) begin
      zrun_q  <= zrun_d;
      miss_q  <= miss_d;
      loss    <= loss_d;
      loss_ev <= cos_mode ? (loss_d != loss) : (loss_d && !loss);
    end else begin
      loss_ev <= 1'b0;
    end
  end
endmodule

// File: rtl/ts16_ais_det.sv
module ts16_ais_det #(
  parameter int unsigned OCTET_W = 8,
  parameter int unsigned MF_LEN  = 16,
  parameter int unsigned AIS_MIN = 4,
  localparam int unsigned FN_W   = $clog2(MF_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [FN_W-1:0]    frame,
  input  logic [OCTET_W-1:0] octet,
  output logic               ais,
  output logic               ais_ev
);
  localparam int unsigned CW = $clog2(OCTET_W * MF_LEN + 1);

  logic [CW-1:0] cnt_q, zc, total;
  logic          quiet, quiet_prev, ais_d;
  logic          is_first, is_last;

  always_comb begin
    zc       = CW'(OCTET_W) - CW'($countones(octet));
    is_first = (frame == '0);
    is_last  = (frame == FN_W'(MF_LEN - 1));
    total    = (is_first ? '0 : cnt_q) + zc;
    quiet    = (total < CW'(AIS_MIN));
    ais_d    = ais;
    if (is_last) begin
      if (!quiet)
        ais_d = 1'b0;
      else if (quiet_prev)
        ais_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      quiet_prev <= 1'b0;
      ais        <= 1'b0;
      ais_ev     <= 1'b0;
    end else if (stb) begin
      cnt_q  <= total;
      ais    <= ais_d;
      ais_ev <= (ais_d != ais);
      if (is_last)
        quiet_prev <= quiet;
    end else begin
      ais_ev <= 1'b0;
    end
  end
endmodule

// File: rtl/ts16_rmt_trk.sv
module ts16_rmt_trk #(
  parameter int unsigned OCTET_W = 8,
  parameter int unsigned RA_BIT  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic               is_f0,
  input  logic [OCTET_W-1:0] octet,
  output logic               rmt,
  output logic               rmt_ev
);
  logic take;

  assign take = stb && is_f0 && (octet[OCTET_W-1 -: 4] == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      rmt    <= 1'b0;
      rmt_ev <= 1'b0;
    end else begin
      rmt_ev <= take && (octet[RA_BIT] != rmt);
      if (take)
        rmt <= octet[RA_BIT];
    end
  end
endmodule

// File: rtl/e1_ts16_alarm_mon.sv
module e1_ts16_alarm_mon
  import e1_ts16_pkg::*;
#(
  parameter int unsigned OCTET_W  = DEF_OCTET_W,
  parameter int unsigned MF_LEN   = DEF_MF_LEN,
  parameter int unsigned MISS_MAX = DEF_MISS_MAX,
  parameter int unsigned ZRUN     = DEF_ZRUN,
  parameter int unsigned AIS_MIN  = DEF_AIS_MIN,
  parameter int unsigned RA_BIT   = DEF_RA_BIT,
  localparam int unsigned FN_W    = $clog2(MF_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ts16_valid,
  input  logic [OCTET_W-1:0] ts16_octet,
  input  logic [FN_W-1:0]    frame_num,
  input  logic               cos_mode,
  output logic               mf_loss,
  output logic               ais16,
  output logic               rmt_alarm,
  output logic               ev_mf_loss,
  output logic               ev_ais16,
  output logic               ev_rmt_alarm
);
  ts16_flags_t lvl, evt;
  logic        is_f0;

  assign is_f0 = (frame_num == '0);

  ts16_mf_align_mon #(
    .OCTET_W (OCTET_W),
    .MISS_MAX(MISS_MAX),
    .ZRUN    (ZRUN)
  ) u_align (
    .clk     (clk),
    .rst     (rst),
    .stb     (ts16_valid),
    .is_f0   (is_f0),
    .octet   (ts16_octet),
    .cos_mode(cos_mode),
    .loss    (lvl.loss),
    .loss_ev (evt.loss)
  );

  ts16_ais_det #(
    .OCTET_W(OCTET_W),
    .MF_LEN (MF_LEN),
    .AIS_MIN(AIS_MIN)
  ) u_ais (
    .clk   (clk),
    .rst   (rst),
    .stb   (ts16_valid),
    .frame (frame_num),
    .octet (ts16_octet),
    .ais   (lvl.ais),
    .ais_ev(evt.ais)
  );

  ts16_rmt_trk #(
    .OCTET_W(OCTET_W),
    .RA_BIT (RA_BIT)
  ) u_rmt (
    .clk   (clk),
    .rst   (rst),
    .stb   (ts16_valid),
    .is_f0 (is_f0),
    .octet (ts16_octet),
    .rmt   (lvl.rmt),
    .rmt_ev(evt.rmt)
  );

  assign mf_loss      = lvl.loss;
  assign ais16        = lvl.ais;
  assign rmt_alarm    = lvl.rmt;
  assign ev_mf_loss   = evt.loss;
  assign ev_ais16     = evt.ais;
  assign ev_rmt_alarm = evt.rmt;
endmodule

// File: rtl/e1_ts16_alarm_chk.sv
module e1_ts16_alarm_chk (
  input logic clk,
  input logic rst,
  input logic ts16_valid,
  input logic cos_mode,
  input logic mf_loss,
  input logic ais16,
  input logic rmt_alarm,
  input logic ev_mf_loss,
  input logic ev_ais16,
  input logic ev_rmt_alarm
);
  p_loss_ev_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_mf_loss && !$past(cos_mode)) |-> (mf_loss && !$past(mf_loss)));

  p_loss_ev_change_r5: assert property (@(posedge clk) disable iff (rst)
    ev_mf_loss |-> (mf_loss != $past(mf_loss)));

  p_ais_ev_valid_r8: assert property (@(posedge clk) disable iff (rst)
    ev_ais16 |-> (ais16 != $past(ais16)));

  p_ais_ev_seen_r8: assert property (@(posedge clk) disable iff (rst)
    (ais16 != $past(ais16)) |-> ev_ais16);

  p_rmt_ev_valid_r9: assert property (@(posedge clk) disable iff (rst)
    ev_rmt_alarm |-> (rmt_alarm != $past(rmt_alarm)));

  p_rmt_ev_seen_r9: assert property (@(posedge clk) disable iff (rst)
    (rmt_alarm != $past(rmt_alarm)) |-> ev_rmt_alarm);

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(ts16_valid) |-> (!ev_mf_loss && !ev_ais16 && !ev_rmt_alarm &&
                            $stable(mf_loss) && $stable(ais16) && $stable(rmt_alarm)));
endmodule

bind e1_ts16_alarm_mon e1_ts16_alarm_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ts16_valid  (ts16_valid),
  .cos_mode    (cos_mode),
  .mf_loss     (mf_loss),
  .ais16       (ais16),
  .rmt_alarm   (rmt_alarm),
  .ev_mf_loss  (ev_mf_loss),
  .ev_ais16    (ev_ais16),
  .ev_rmt_alarm(ev_rmt_alarm)
);

// File: tb/e1_ts16_alarm_mon_bench.sv
module e1_ts16_alarm_mon_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ts16_valid = 1'b0;
  logic [7:0] ts16_octet = 8'h00;
  logic [3:0] frame_num = 4'd0;
  logic       cos_mode = 1'b0;
  logic       mf_loss, ais16, rmt_alarm, ev_mf_loss, ev_ais16, ev_rmt_alarm;

  int total = 0;
  int bad = 0;
  int n_loss_ev = 0;
  int n_ais_ev = 0;
  int n_rmt_ev = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e1_ts16_alarm_mon u_e1_ts16_alarm_mon (
    .clk         (clk),
    .rst         (rst),
    .ts16_valid  (ts16_valid),
    .ts16_octet  (ts16_octet),
    .frame_num   (frame_num),
    .cos_mode    (cos_mode),
    .mf_loss     (mf_loss),
    .ais16       (ais16),
    .rmt_alarm   (rmt_alarm),
    .ev_mf_loss  (ev_mf_loss),
    .ev_ais16    (ev_ais16),
    .ev_rmt_alarm(ev_rmt_alarm)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] fr, input logic [7:0] b);
    @(negedge clk);
    frame_num  = fr;
    ts16_octet = b;
    ts16_valid = 1'b1;
    @(negedge clk);
    ts16_valid = 1'b0;
    n_loss_ev += int'(ev_mf_loss);
    n_ais_ev  += int'(ev_ais16);
    n_rmt_ev  += int'(ev_rmt_alarm);
  endtask

  task automatic send_mf(input logic [7:0] b0, input logic [7:0] bx,
                         input int zf, input logic [7:0] zb);
    for (int f = 0; f < 16; f++)
      send(4'(f), (f == 0) ? b0 : ((f == zf) ? zb : bx));
  endtask

  task automatic t_reset();
    check("R1 mf_loss", int'(mf_loss), 0);
    check("R1 ais16", int'(ais16), 0);
    check("R1 rmt_alarm", int'(rmt_alarm), 0);
    check("R1 events", int'(ev_mf_loss | ev_ais16 | ev_rmt_alarm), 0);
  endtask

  task automatic t_miss();
    int e0;
    cos_mode = 1'b0;
    send(4'd0, 8'h0B);
    send(4'd0, 8'h8B);
    check("R2 single miss", int'(mf_loss), 0);
    send(4'd0, 8'h0B);
    send(4'd0, 8'h8B);
    check("R2 miss then match", int'(mf_loss), 0);
    e0 = n_loss_ev;
    send(4'd0, 8'h9B);
    check("R2 two misses", int'(mf_loss), 1);
    check("R5 rise event cos=0", n_loss_ev - e0, 1);
    send(4'd0, 8'h0B);
    check("R4 match clears", int'(mf_loss), 0);
    check("R5 no fall event cos=0", n_loss_ev - e0, 1);
  endtask

  task automatic t_cos();
    int e0;
    @(negedge clk);
    cos_mode = 1'b1;
    e0 = n_loss_ev;
    send(4'd0, 8'h8B);
    send(4'd0, 8'h8B);
    check("R5 cos rise level", int'(mf_loss), 1);
    check("R5 cos rise event", n_loss_ev - e0, 1);
    send(4'd0, 8'h0B);
    check("R5 cos fall level", int'(mf_loss), 0);
    check("R5 cos fall event", n_loss_ev - e0, 2);
    @(negedge clk);
    cos_mode = 1'b0;
  endtask

  task automatic t_zero_run();
    for (int f = 1; f < 16; f++) send(4'(f), 8'h00);
    check("R3 fifteen zeros", int'(mf_loss), 0);
    send(4'd0, 8'h0B);
    for (int f = 1; f < 16; f++) send(4'(f), 8'h00);
    check("R3 run of fifteen", int'(mf_loss), 0);
    send(4'd0, 8'h00);
    check("R3 sixteenth zero", int'(mf_loss), 1);
    for (int f = 1; f < 16; f++) send(4'(f), 8'h00);
    send(4'd0, 8'h00);
    check("R4 zero frame0 inside run no clear", int'(mf_loss), 1);
    send(4'd1, 8'h55);
    send(4'd0, 8'h0B);
    check("R4 clear after run broken", int'(mf_loss), 0);
  endtask

  task automatic t_ais();
    int e0;
    e0 = n_ais_ev;
    send_mf(8'hFF, 8'hFF, 99, 8'hFF);
    check("R6 one quiet multiframe", int'(ais16), 0);
    for (int f = 0; f < 15; f++) send(4'(f), 8'hFF);
    check("R6 not before frame 15", int'(ais16), 0);
    send(4'd15, 8'hFF);
    check("R6 two quiet multiframes", int'(ais16), 1);
    check("R8 set event", n_ais_ev - e0, 1);
    send_mf(8'hFF, 8'hFF, 5, 8'hF8);
    check("R6 three zeros keeps ais", int'(ais16), 1);
    check("R8 no event on hold", n_ais_ev - e0, 1);
    send_mf(8'hFF, 8'hFF, 5, 8'hF0);
    check("R7 four zeros clears", int'(ais16), 0);
    check("R8 clear event", n_ais_ev - e0, 2);
    send_mf(8'hFF, 8'hFF, 5, 8'hF8);
    check("R6 first quiet after clear", int'(ais16), 0);
    send_mf(8'hFF, 8'hFF, 9, 8'hF8);
    check("R6 second quiet after clear", int'(ais16), 1);
    check("R8 event count", n_ais_ev - e0, 3);
  endtask

  task automatic t_rmt();
    int e0;
    e0 = n_rmt_ev;
    send(4'd0, 8'h0F);
    check("R9 bit2 set", int'(rmt_alarm), 1);
    check("R9 rise event", n_rmt_ev - e0, 1);
    send(4'd3, 8'h00);
    check("R9 other frame ignored", int'(rmt_alarm), 1);
    send(4'd0, 8'hFB);
    check("R9 mismatch frame0 ignored", int'(rmt_alarm), 1);
    check("R9 no event when ignored", n_rmt_ev - e0, 1);
    send(4'd0, 8'h0B);
    check("R9 bit2 clear", int'(rmt_alarm), 0);
    check("R9 fall event", n_rmt_ev - e0, 2);
    send(4'd0, 8'h0B);
    check("R9 no event unchanged", n_rmt_ev - e0, 2);
  endtask

  task automatic t_quiet();
    logic l0, a0, r0;
    send(4'd0, 8'h8F);
    l0 = mf_loss; a0 = ais16; r0 = rmt_alarm;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ts16_octet = 8'(k * 37);
      frame_num  = 4'd0;
      @(negedge clk);
      check("R10 no strobe event", int'(ev_mf_loss | ev_ais16 | ev_rmt_alarm), 0);
      check("R10 levels hold", int'({mf_loss, ais16, rmt_alarm}), int'({l0, a0, r0}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss();
    t_cos();
    t_zero_run();
    t_ais();
    t_rmt();
    t_quiet();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule